// File: doc/BRIEF.md
# Up-Counter with Selectable Wrap Limit and Three Compare Channels

This block is a 16-bit up-counter. It moves forward one step on each cycle where the timer-clock enable pulse `tick` is high, but only while a clock source is selected. A non-zero `clk_sel` means a source is selected. When `clk_sel` is zero, the counter holds its value. The counter counts from zero up to a limit, called TOP, and then returns to zero. The `mode` input chooses TOP. It can be one of three fixed 8/9/10-bit limits, the full 16-bit range, the active value of compare channel 0, or a separately written limit register.

Three compare channels watch the counter on every enabled step. Each channel has a sticky match flag and a waveform output that can toggle on each match. Compare values are written into a buffer first. They reach the active comparators only at a safe point: when the counter wraps from TOP, or at any time while the counter is stopped. This means a running count never sees a compare or TOP value change in the middle of a period. When channel 0 serves as TOP, its waveform output is forced low. The separate limit register lets channel 0 remain free for waveform use. An overflow flag records each time the counter wraps past 0xFFFF.

Top module: `sel_top_counter`

## Requirements
- R1: During and right after reset, `count` is 0x0000, and `match_flag`, `ovf_flag` and `wave` are all zero.
- R2: While `clk_sel` is 0, `count` keeps its value whatever `tick` does.
- R3: An enabled step is a cycle with `tick`=1 and `clk_sel`≠0. Each enabled step below TOP adds one to `count`. A cycle with `tick`=0 leaves `count` unchanged.
- R4: TOP depends on `mode`:
  - 0 gives 0xFFFF.
  - 1 gives 0x00FF.
  - 2 gives 0x01FF.
  - 3 gives 0x03FF.
  - 4 gives the active compare value of channel 0.
  - 5 gives the limit register.
  - 6 and 7 behave as 0.

  An enabled step taken with `count` equal to TOP loads 0x0000.
- R5: `ovf_flag` sets after an enabled step taken with `count` at 0xFFFF. It does not set on a wrap from any lower TOP. A one on `ovf_clr` clears it, unless a set happens in the same cycle.
- R6: `match_flag[i]` sets after an enabled step taken with `count` equal to channel i's active compare value. It stays set until a cycle with `flag_clr[i]`=1 and no set in that cycle; a set and a clear together leave it set.
- R7: A cycle with `cmp_wr[i]`=1 stores `wr_data` in channel i's buffer. The buffer is copied to the active compare value on an enabled step that wraps from TOP, and on every cycle in which `clk_sel` is 0. A value written while running does not act before the next wrap.
- R8: A cycle with `cap_wr`=1 stores `wr_data` in the limit register used by mode 5. The new limit acts from the next cycle, with no buffering.
- R9: With `tgl_en[i]`=1, `wave[i]` inverts on every match of channel i. With `tgl_en[i]`=0, `wave[i]` is driven low from the next cycle.
- R10: While `mode` is 4, `wave[0]` is driven low from the next cycle, whatever `tgl_en[0]` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timer-clock enable pulse |
| clk_sel | input | 3 | Clock source select; 0 means stopped |
| mode | input | 3 | TOP selection (see R4) |
| cmp_wr | input | 3 | Per-channel compare buffer write strobe |
| cap_wr | input | 1 | Limit register write strobe |
| wr_data | input | 16 | Write data for compare buffers and limit register |
| tgl_en | input | 3 | Per-channel toggle-on-match enable |
| flag_clr | input | 3 | Per-channel match flag clear, write one |
| ovf_clr | input | 1 | Overflow flag clear |
| count | output | 16 | Counter value |
| match_flag | output | 3 | Sticky compare match flags |
| ovf_flag | output | 1 | Sticky overflow flag |
| wave | output | 3 | Per-channel waveform outputs |

## Verification
The assertions check, on every cycle, the properties that depend only on nearby cycles:
- the counter freezing while stopped;
- single-step increments under the fixed limits;
- the wrap at 0x00FF;
- overflow on leaving 0xFFFF;
- sticky match flags;
- the forced-low waveform rules.

Only the bench's scenarios can show the double-buffer timing. In those scenarios, an old compare value stays in force until the wrap that follows a write made while running, and a TOP change in mode 4 waits for that wrap. The scenarios also cover the unbuffered limit register, the 0x01FF and 0x03FF limits, and the toggle sequence over several periods.

// File: rtl/sel_top_counter.sv
module sel_top_counter #(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [2:0]     clk_sel,
  input  logic [2:0]     mode,
  input  logic [NCH-1:0] cmp_wr,
  input  logic           cap_wr,
  input  logic [W-1:0]   wr_data,
  input  logic [NCH-1:0] tgl_en,
  input  logic [NCH-1:0] flag_clr,
  input  logic           ovf_clr,
  output logic [W-1:0]   count,
  output logic [NCH-1:0] match_flag,
  output logic           ovf_flag,
  output logic [NCH-1:0] wave
);
  localparam logic [W-1:0] LIM8  = W'(255);
  localparam logic [W-1:0] LIM9  = W'(511);
  localparam logic [W-1:0] LIM10 = W'(1023);
  localparam logic [W-1:0] LIMAX = '1;
  localparam logic [W-1:0] ONE   = W'(1);

  logic [W-1:0] cmp_buf [NCH];
  logic [W-1:0] cmp_act [NCH];
  logic [W-1:0] cap_reg;
  logic [W-1:0] top;

  wire running = (clk_sel != 3'd0);
  wire adv     = tick & running;
  wire wrap    = adv & (count == top);
  wire xfer    = wrap | ~running;

  always_comb begin
    case (mode)
      3'd1:    top = LIM8;
      3'd2:    top = LIM9;
      3'd3:    top = LIM10;
      3'd4:    top = cmp_act[0];
      3'd5:    top = cap_reg;
      default: top = LIMAX;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (wrap) count <= '0;
    else if (adv)  count <= count + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ovf_flag <= 1'b0;
    else if (adv && count == LIMAX)  ovf_flag <= 1'b1;
    else if (ovf_clr)                ovf_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_reg <= '0;
    else if (cap_wr) cap_reg <= wr_data;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire hit     = adv & (count == cmp_act[i]);
    wire blocked = (i == 0) && (mode == 3'd4);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_buf[i] <= '0;
        cmp_act[i] <= '0;
      end else begin
        if (cmp_wr[i]) cmp_buf[i] <= wr_data;
        if (xfer)      cmp_act[i] <= cmp_buf[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           match_flag[i] <= 1'b0;
      else if (hit)         match_flag[i] <= 1'b1;
      else if (flag_clr[i]) match_flag[i] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    wave[i] <= 1'b0;
      else if (!tgl_en[i] || blocked) wave[i] <= 1'b0;
      else if (hit)                  wave[i] <= ~wave[i];
    end
  end
endmodule

// File: rtl/sel_top_counter_chk.sv
module sel_top_counter_chk #(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic [2:0]     clk_sel,
  input logic [2:0]     mode,
  input logic [NCH-1:0] tgl_en,
  input logic [NCH-1:0] flag_clr,
  input logic [W-1:0]   count,
  input logic [NCH-1:0] match_flag,
  input logic           ovf_flag,
  input logic [NCH-1:0] wave
);
  localparam logic [W-1:0] LIM8 = W'(255);

  // R1
  always @(posedge clk)
    if (!rst_n) reset_state_chk: assert (count == '0 && match_flag == '0 && !ovf_flag && wave == '0);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0) |=> $stable(count));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clk_sel != 3'd0 && mode <= 3'd3 && count < LIM8) |=> (count == $past(count) + W'(1)));

  // R4
  wrap_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clk_sel != 3'd0 && mode == 3'd1 && count == LIM8) |=> (count == '0));

  // R5
  max_wrap_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clk_sel != 3'd0 && count == '1) |=> (ovf_flag && count == '0));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((match_flag & $past(match_flag & ~flag_clr)) == $past(match_flag & ~flag_clr)));

  // R9
  wave_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wave & ~$past(tgl_en)) == '0));

  // R10
  wave_a_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |=> !wave[0]);
endmodule

bind sel_top_counter sel_top_counter_chk #(.W(W), .NCH(NCH)) u_chk (.*);

// File: tb/test_sel_top_counter.sv
module test_sel_top_counter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, cap_wr = 1'b0, ovf_clr = 1'b0;
  logic [2:0] clk_sel = '0, mode = '0, cmp_wr = '0, tgl_en = '0, flag_clr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic [2:0] match_flag, wave;
  logic ovf_flag;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sel_top_counter i_sel_top_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clk_sel(clk_sel), .mode(mode),
    .cmp_wr(cmp_wr), .cap_wr(cap_wr), .wr_data(wr_data), .tgl_en(tgl_en),
    .flag_clr(flag_clr), .ovf_clr(ovf_clr), .count(count),
    .match_flag(match_flag), .ovf_flag(ovf_flag), .wave(wave));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic advance(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    tick = 1'b0;
  endtask

  task automatic wr_cmp(input int ch, input logic [15:0] v);
    wr_data = v; cmp_wr = 3'b001 << ch;
    idle(1);
    cmp_wr = '0;
  endtask

  task automatic clear_all();
    flag_clr = 3'b111; ovf_clr = 1'b1;
    idle(1);
    flag_clr = '0; ovf_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 flags", {match_flag, ovf_flag}, 0);
    chk("R1 wave", wave, 0);
  endtask

  task automatic t_stopped();
    clk_sel = 3'd0;
    advance(5);
    chk("R2 stopped count", count, 0);
  endtask

  task automatic t_byte_top();
    wr_cmp(0, 16'h0010); wr_cmp(1, 16'h0020); wr_cmp(2, 16'h0005);
    idle(1);
    mode = 3'd1; tgl_en = 3'b111; clk_sel = 3'd1;
    advance(10);
    chk("R3 count", count, 10);
    chk("R6 flags", match_flag, 3'b100);
    chk("R9 wave", wave, 3'b100);
    idle(3);
    chk("R3 no tick hold", count, 10);
    advance(245);
    chk("R4 at 0xFF", count, 16'h00FF);
    advance(1);
    chk("R4 wrap 0xFF", count, 0);
    chk("R5 no ovf", ovf_flag, 0);
    chk("R6 all set", match_flag, 3'b111);
    clear_all();
    chk("R6 cleared", match_flag, 0);
  endtask

  task automatic t_set_wins();
    advance(5);
    chk("R6 before hit", match_flag[2], 0);
    flag_clr = 3'b100;
    advance(1);
    flag_clr = '0;
    chk("R6 set wins", match_flag[2], 1);
    flag_clr = 3'b100;
    idle(1);
    flag_clr = '0;
    chk("R6 clear", match_flag[2], 0);
  endtask

  task automatic t_double_buffer();
    tgl_en = 3'b101;
    wr_cmp(1, 16'h0030);
    advance(26);
    chk("R7 at 0x20", count, 16'h0020);
    advance(1);
    chk("R7 old value still active", match_flag[1], 1);
    chk("R9 toggle off low", wave[1], 0);
    clear_all();
    advance(223);
    chk("R7 wrap", count, 0);
    advance(16'h21);
    chk("R7 old value gone", match_flag[1], 0);
    advance(16'h10);
    chk("R7 new value active", match_flag[1], 1);
    chk("R9 wave0 after 3 hits", wave[0], 1);
    advance(207);
    chk("R4 wrap again", count, 0);
  endtask

  task automatic t_top_a();
    clk_sel = 3'd0;
    wr_cmp(0, 16'h0007);
    idle(1);
    mode = 3'd4; clk_sel = 3'd2;
    idle(1);
    chk("R10 wave0 low", wave[0], 0);
    advance(7);
    chk("R4 A top reach", count, 7);
    advance(1);
    chk("R4 A top wrap", count, 0);
    wr_cmp(0, 16'h0003);
    advance(7);
    chk("R7 old TOP kept", count, 7);
    advance(1);
    advance(3);
    chk("R7 new TOP reach", count, 3);
    advance(1);
    chk("R7 new TOP wrap", count, 0);
    chk("R10 wave0 still low", wave[0], 0);
  endtask

  task automatic t_cap_top();
    wr_data = 16'h0004; cap_wr = 1'b1;
    idle(1);
    cap_wr = 1'b0;
    mode = 3'd5;
    advance(4);
    chk("R8 cap top reach", count, 4);
    chk("R9 wave0 toggles when free", wave[0], 1);
    advance(1);
    chk("R8 cap top wrap", count, 0);
  endtask

  task automatic t_wide_tops();
    mode = 3'd2;
    advance(16'h01FF);
    chk("R4 at 0x1FF", count, 16'h01FF);
    advance(1);
    chk("R4 wrap 0x1FF", count, 0);
    mode = 3'd3;
    advance(16'h03FF);
    chk("R4 at 0x3FF", count, 16'h03FF);
    advance(1);
    chk("R4 wrap 0x3FF", count, 0);
    chk("R5 no ovf below max", ovf_flag, 0);
  endtask

  task automatic t_overflow();
    mode = 3'd0;
    advance(16'hFFFF);
    chk("R5 at max", count, 16'hFFFF);
    chk("R5 not yet", ovf_flag, 0);
    advance(1);
    chk("R5 wrap count", count, 0);
    chk("R5 ovf set", ovf_flag, 1);
    ovf_clr = 1'b1;
    idle(1);
    ovf_clr = 1'b0;
    chk("R5 ovf clear", ovf_flag, 0);
  endtask

  initial begin
    idle(2);
    t_reset();
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_stopped();
    t_byte_top();
    t_set_wins();
    t_double_buffer();
    t_top_a();
    t_cap_top();
    t_wide_tops();
    t_overflow();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule